// File: doc/BRIEF.md
# Start/Stop Framed Serial Word Aligner

This block takes a serial bit stream delivered two bits per fast clock cycle, as a pair of double-data-rate input registers would present it, and recovers the word boundaries of 20-bit frames. Each frame is a single high start bit, then 18 payload bits sent most significant first, then a single low stop bit. The block has no strobe that marks frame edges. It finds them by searching every candidate bit offset for the start-high/stop-low signature, then confirms that offset over later frames before it trusts it.

The block runs through three phases. While hunting, it tests the two frame windows that end on the two newly arrived bits in every cycle. While verifying, it re-checks the chosen offset once per frame, which is every 10 fast cycles. While locked, it emits each well-framed payload as an 18-bit word with a one-cycle valid strobe, and raises an error pulse for each badly framed frame. Lock needs four consecutive good frames and is released after four consecutive bad ones. Clock recovery, pad primitives and the move into the word-clock domain are handled elsewhere.

Top module: `sfa_frame_aligner`

## Requirements
- R1: While the synchronous active-high reset is held, `locked_o`, `word_valid_o` and `frame_err_o` are 0 and `word_o` is 0. After reset the block is hunting, and an all-zero input stream never produces lock, a valid word or an error pulse.
- R2: `pair_i[1]` is the earlier bit of a pair and `pair_i[0]` is the later one. A frame is 1 start bit of value 1, then 18 data bits with the most significant first, then 1 stop bit of value 0. `word_o[17]` holds the first data bit received.
- R3: A frame stream is aligned whatever its starting bit offset, at every one of the 20 offsets, including offsets where a frame ends on the earlier bit of a pair.
- R4: Lock is declared after 4 consecutive frames pass framing at the same offset. The first of these is the frame found while hunting. Every frame from the fifth onward is output.
- R5: A framing failure while verifying returns the block to hunting, and lock is not declared.
- R6: `word_valid_o` is high for exactly one cycle per accepted frame, and only while `locked_o` is high. Successive framing events while locked are at least 10 cycles apart.
- R7: A frame that fails framing while locked raises `frame_err_o` for one cycle, produces no valid strobe and leaves `word_o` unchanged.
- R8: Up to 3 consecutive framing failures keep the block locked, and one good frame clears the failure count.
- R9: A 4th consecutive framing failure drops `locked_o` and returns the block to hunting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock, one bit pair per cycle |
| rst | input | 1 | Synchronous active-high reset |
| pair_i | input | 2 | Bit pair; bit 1 arrived earlier than bit 0 |
| word_o | output | 18 | Last accepted payload, first-received bit in bit 17 |
| word_valid_o | output | 1 | One-cycle strobe for each accepted frame |
| frame_err_o | output | 1 | One-cycle pulse for each failed frame while locked |
| locked_o | output | 1 | High while frame alignment is locked |

## Verification
The hardest situations to reach from the ports are frames that end on the earlier bit of a pair and a verification failure partway through lock acquisition. The stimulus sweeps the idle prefix before the stream across all 20 lengths, so every bit offset and both pair phases are hit. A separate sequence breaks the third frame's start bit and uses all-zero payloads, so that no false window can match while the block hunts again. Failure bursts of lengths three and four while locked separate holding the lock from releasing it.

// File: rtl/sfa_pkg.sv
package sfa_pkg;

    localparam int SFA_DATA_W   = 18;
    localparam int SFA_LOCK_N   = 4;
    localparam int SFA_UNLOCK_N = 4;

    typedef enum logic [1:0] {
        ST_HUNT   = 2'd0,
        ST_VERIFY = 2'd1,
        ST_LOCKED = 2'd2
    } align_state_e;

    // Framing test on one window: top bit is the start, bottom bit the stop.
    function automatic logic framing_ok(input logic start_bit, input logic stop_bit);
        return start_bit & ~stop_bit;
    endfunction

endpackage

// File: rtl/sfa_pair_shift.sv
module sfa_pair_shift #(
    parameter int HIST_W = 21
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        pair_i,
    output logic [HIST_W-1:0] hist_o
);
    // Newest bit in position 0; pair_i[1] is older than pair_i[0].
    always_ff @(posedge clk) begin
        if (rst) begin
            hist_o <= '0;
        end else begin
            hist_o <= {hist_o[HIST_W-3:0], pair_i[1], pair_i[0]};
        end
    end
endmodule

// File: rtl/sfa_window_check.sv
module sfa_window_check
    import sfa_pkg::*;
#(
    parameter int DATA_W = 18
) (
    input  logic [DATA_W+2:0]            hist_i,
    output logic [1:0]                   pass_o,
    output logic [1:0][DATA_W-1:0]       data_o
);
    localparam int FRAME_W = DATA_W + 2;

    // Phase 0: frame ends on the later bit of the pair; phase 1: on the earlier.
    for (genvar p = 0; p < 2; p++) begin : g_phase
        logic [FRAME_W-1:0] win;
        assign win       = hist_i[p +: FRAME_W];
        assign pass_o[p] = framing_ok(win[FRAME_W-1], win[0]);
        assign data_o[p] = win[FRAME_W-2:1];
    end
endmodule

// File: rtl/sfa_lock_fsm.sv
module sfa_lock_fsm
    import sfa_pkg::*;
#(
    parameter int DATA_W   = 18,
    parameter int SLOT_N   = 10,
    parameter int LOCK_N   = 4,
    parameter int UNLOCK_N = 4
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [1:0]               pass_i,
    input  logic [1:0][DATA_W-1:0]   data_i,
    output logic [DATA_W-1:0]        word_o,
    output logic                     valid_o,
    output logic                     err_o,
    output logic                     locked_o
);
    localparam int SW = $clog2(SLOT_N);
    localparam int GW = $clog2(LOCK_N + 1);
    localparam int BW = $clog2(UNLOCK_N + 1);

    align_state_e      state;
    logic              phase;
    logic [SW-1:0]     slot;
    logic [GW-1:0]     good_cnt;
    logic [BW-1:0]     bad_cnt;
    logic              sel_pass;
    logic [DATA_W-1:0] sel_data;
    logic              at_slot;

    assign sel_pass = pass_i[phase];
    assign sel_data = data_i[phase];
    assign at_slot  = (slot == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_HUNT;
            phase    <= 1'b0;
            slot     <= '0;
            good_cnt <= '0;
            bad_cnt  <= '0;
            word_o   <= '0;
            valid_o  <= 1'b0;
            err_o    <= 1'b0;
            locked_o <= 1'b0;
        end else begin
            valid_o <= 1'b0;
            err_o   <= 1'b0;
            if (state != ST_HUNT) begin
                slot <= at_slot ? SW'(SLOT_N - 1) : slot - SW'(1);
            end
            unique case (state)
                ST_HUNT: begin
                    if (pass_i != 2'b00) begin
                        phase    <= pass_i[1];
                        slot     <= SW'(SLOT_N - 1);
                        good_cnt <= GW'(1);
                        state    <= ST_VERIFY;
                    end
                end
                ST_VERIFY: begin
                    if (at_slot) begin
                        if (!sel_pass) begin
                            state <= ST_HUNT;
                        end else if (good_cnt == GW'(LOCK_N - 1)) begin
                            state    <= ST_LOCKED;
                            locked_o <= 1'b1;
                            bad_cnt  <= '0;
                        end else begin
                            good_cnt <= good_cnt + GW'(1);
                        end
                    end
                end
                ST_LOCKED: begin
                    if (at_slot) begin
                        if (sel_pass) begin
                            valid_o <= 1'b1;
                            word_o  <= sel_data;
                            bad_cnt <= '0;
                        end else begin
                            err_o <= 1'b1;
                            if (bad_cnt == BW'(UNLOCK_N - 1)) begin
                                state    <= ST_HUNT;
                                locked_o <= 1'b0;
                            end else begin
                                bad_cnt <= bad_cnt + BW'(1);
                            end
                        end
                    end
                end
                default: state <= ST_HUNT;
            endcase
        end
    end
endmodule

// File: rtl/sfa_frame_aligner.sv
module sfa_frame_aligner
    import sfa_pkg::*;
#(
    parameter int DATA_W   = SFA_DATA_W,
    parameter int LOCK_N   = SFA_LOCK_N,
    parameter int UNLOCK_N = SFA_UNLOCK_N
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        pair_i,
    output logic [DATA_W-1:0] word_o,
    output logic              word_valid_o,
    output logic              frame_err_o,
    output logic              locked_o
);
    localparam int FRAME_W = DATA_W + 2;
    localparam int HIST_W  = FRAME_W + 1;
    localparam int SLOT_N  = FRAME_W / 2;

    logic [HIST_W-1:0]       hist;
    logic [1:0]              pass;
    logic [1:0][DATA_W-1:0]  cand;

    sfa_pair_shift #(.HIST_W(HIST_W)) u_shift (
        .clk    (clk),
        .rst    (rst),
        .pair_i (pair_i),
        .hist_o (hist)
    );

    sfa_window_check #(.DATA_W(DATA_W)) u_check (
        .hist_i (hist),
        .pass_o (pass),
        .data_o (cand)
    );

    sfa_lock_fsm #(
        .DATA_W   (DATA_W),
        .SLOT_N   (SLOT_N),
        .LOCK_N   (LOCK_N),
        .UNLOCK_N (UNLOCK_N)
    ) u_fsm (
        .clk      (clk),
        .rst      (rst),
        .pass_i   (pass),
        .data_i   (cand),
        .word_o   (word_o),
        .valid_o  (word_valid_o),
        .err_o    (frame_err_o),
        .locked_o (locked_o)
    );
endmodule

// File: rtl/sfa_frame_aligner_chk.sv
module sfa_frame_aligner_chk #(
    parameter int DATA_W = 18
) (
    input logic              clk,
    input logic              rst,
    input logic [DATA_W-1:0] word_o,
    input logic              word_valid_o,
    input logic              frame_err_o,
    input logic              locked_o
);
    localparam int SLOT_N = (DATA_W + 2) / 2;

    logic [7:0] gap;
    logic       armed;

    always_ff @(posedge clk) begin
        if (rst) begin
            gap   <= '0;
            armed <= 1'b0;
        end else if (word_valid_o || frame_err_o) begin
            gap   <= '0;
            armed <= 1'b1;
        end else if (gap != 8'hFF) begin
            gap <= gap + 8'd1;
        end
    end

    AST_VALID_WHILE_LOCKED: assert property (@(posedge clk) disable iff (rst)
        word_valid_o |-> locked_o);                                       // R6
    AST_VALID_ERR_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        !(word_valid_o && frame_err_o));                                  // R7
    AST_EVENT_SPACING: assert property (@(posedge clk) disable iff (rst)
        ((word_valid_o || frame_err_o) && armed) |-> (gap >= 8'(SLOT_N - 1))); // R6
    AST_ERR_FROM_LOCK: assert property (@(posedge clk) disable iff (rst)
        frame_err_o |-> $past(locked_o));                                 // R7
    AST_UNLOCK_ON_ERR: assert property (@(posedge clk) disable iff (rst)
        $fell(locked_o) |-> frame_err_o);                                 // R9
    AST_WORD_HOLD: assert property (@(posedge clk) disable iff (rst)
        !word_valid_o |-> $stable(word_o));                               // R7
endmodule

bind sfa_frame_aligner sfa_frame_aligner_chk #(.DATA_W(DATA_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .word_o       (word_o),
    .word_valid_o (word_valid_o),
    .frame_err_o  (frame_err_o),
    .locked_o     (locked_o)
);

// File: tb/sfa_frame_aligner_tb.sv
`timescale 1ns/1ps
module sfa_frame_aligner_tb;
    localparam int DW = 18;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [1:0]    pair = 2'b00;
    logic [DW-1:0] word;
    logic          wvalid, ferr, locked;

    int total = 0, failed = 0;
    bit            q[$];
    logic [DW-1:0] got[$];
    int            err_n, bad_valid, err_word_bad;
    bit            ever_locked;

    always #2.5 clk = ~clk;

    sfa_frame_aligner u_dut (
        .clk(clk), .rst(rst), .pair_i(pair),
        .word_o(word), .word_valid_o(wvalid), .frame_err_o(ferr), .locked_o(locked)
    );

    always @(negedge clk) begin
        if (!rst) begin
            if (wvalid) got.push_back(word);
            if (ferr) begin
                err_n++;
                if (got.size() > 0 && word != got[got.size()-1]) err_word_bad++;
            end
            if (wvalid && !locked) bad_valid++;
            if (locked) ever_locked = 1'b1;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            failed++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] pat(input int i, input int seed);
        case (i % 6)
            0: return 18'h00000;
            1: return 18'h3FFFF;
            2: return 18'h2AAAA;
            3: return 18'h15555;
            4: return 18'h20001;
            default: return DW'(i * 32'h0B3A7 + seed * 32'h1F3 + 32'h2AAAA);
        endcase
    endfunction

    task automatic push_frame(input logic [DW-1:0] d, input bit st, input bit sp);
        q.push_back(st);
        for (int i = DW-1; i >= 0; i--) q.push_back(d[i]);
        q.push_back(sp);
    endtask

    task automatic push_idle(input int n);
        for (int i = 0; i < n; i++) q.push_back(1'b0);
    endtask

    task automatic drain();
        bit b1, b0;
        while (q.size() > 0) begin
            @(negedge clk);
            b1 = q.pop_front();
            b0 = (q.size() > 0) ? q.pop_front() : 1'b0;
            pair = {b1, b0};
        end
        repeat (3) begin
            @(negedge clk);
            pair = 2'b00;
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        pair = 2'b00;
        repeat (2) @(negedge clk);
        got.delete();
        q.delete();
        err_n = 0; bad_valid = 0; err_word_bad = 0; ever_locked = 1'b0;
        rst = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        chk(1'b0, "watchdog", 0, 1);
        $display("%0d/%0d checks passed", total - failed, total);
        $finish;
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        chk(locked == 1'b0, "R1 locked", locked, 0);
        chk(wvalid == 1'b0, "R1 valid", wvalid, 0);
        chk(ferr == 1'b0, "R1 err", ferr, 0);
        chk(word == '0, "R1 word", word, 0);
        do_reset();
        push_idle(200);
        drain();
        chk(!ever_locked && got.size() == 0 && err_n == 0, "R1 idle hunt", got.size(), 0);

        // R2, R4: aligned stream, frames 4.. are output in order
        do_reset();
        push_idle(20);
        for (int i = 0; i < 10; i++) push_frame(pat(i, 1), 1'b1, 1'b0);
        drain();
        chk(got.size() == 6, "R4 word count", got.size(), 6);
        for (int i = 0; i < 6; i++)
            if (i < got.size()) chk(got[i] == pat(i + 4, 1), "R2 word content", got[i], pat(i + 4, 1));
        chk(locked == 1'b1, "R4 locked", locked, 1);
        chk(bad_valid == 0, "R6 valid only when locked", bad_valid, 0);
        chk(err_n == 0, "R6 no errors on clean stream", err_n, 0);

        // R4: only 4 frames -> lock but no word yet
        do_reset();
        push_idle(20);
        for (int i = 0; i < 4; i++) push_frame(pat(i, 2), 1'b1, 1'b0);
        drain();
        chk(locked == 1'b1 && got.size() == 0, "R4 lock at fourth frame", got.size(), 0);

        // R3: sweep every bit offset
        for (int k = 0; k < 20; k++) begin
            do_reset();
            push_idle(20 + k);
            for (int i = 0; i < 7; i++) push_frame(pat(i + k, k), 1'b1, 1'b0);
            drain();
            chk(got.size() == 3, $sformatf("R3 count offset %0d", k), got.size(), 3);
            for (int i = 0; i < 3; i++)
                if (i < got.size())
                    chk(got[i] == pat(i + 4 + k, k), $sformatf("R3 word offset %0d", k), got[i], pat(i + 4 + k, k));
            chk(locked == 1'b1, $sformatf("R3 locked offset %0d", k), locked, 1);
        end

        // R5: verify failure (third frame lacks its start bit), zero payloads
        do_reset();
        push_idle(21);
        push_frame('0, 1'b1, 1'b0);
        push_frame('0, 1'b1, 1'b0);
        push_frame('0, 1'b0, 1'b0);
        for (int i = 0; i < 3; i++) push_frame('0, 1'b1, 1'b0);
        push_idle(40);
        drain();
        chk(!ever_locked, "R5 no lock after verify fail", ever_locked, 0);
        chk(got.size() == 0, "R5 no words", got.size(), 0);

        // R7, R8, R9: failure bursts while locked
        do_reset();
        push_idle(20);
        for (int i = 0; i < 6; i++) push_frame(pat(i, 3), 1'b1, 1'b0);
        push_frame('0, 1'b1, 1'b1);
        push_frame('0, 1'b0, 1'b0);
        push_frame('0, 1'b1, 1'b1);
        push_frame(18'h1234A, 1'b1, 1'b0);
        for (int i = 0; i < 3; i++) push_frame('0, 1'b1, 1'b1);
        push_frame(18'h0ABCD, 1'b1, 1'b0);
        drain();
        chk(locked == 1'b1, "R8 lock held over 3 failures", locked, 1);
        chk(err_n == 6, "R7 error pulses", err_n, 6);
        chk(got.size() == 4, "R7 no word for failed frames", got.size(), 4);
        if (got.size() == 4) begin
            chk(got[2] == 18'h1234A, "R8 good frame after failures", got[2], 18'h1234A);
            chk(got[3] == 18'h0ABCD, "R8 count cleared", got[3], 18'h0ABCD);
        end
        chk(err_word_bad == 0, "R7 word held on error", err_word_bad, 0);
        for (int i = 0; i < 4; i++) push_frame('0, 1'b1, 1'b1);
        drain();
        chk(locked == 1'b0, "R9 unlock after 4 failures", locked, 0);
        chk(err_n == 10, "R9 error pulses", err_n, 10);
        chk(got.size() == 4, "R9 no words after unlock", got.size(), 4);
        chk(bad_valid == 0, "R6 valid only when locked", bad_valid, 0);

        $display("%0d/%0d checks passed", total - failed, total);
        $finish;
    end
endmodule